// File: doc/BRIEF.md
# Configurable Multi-Output Logic Cell

This block is one cell of a programmable logic fabric. Four sum-of-products terms (`sum_a`..`sum_d`) arrive from a logic array. A static configuration word, `cfg`, sets what each term does: register data, clock, preset, reset, output enable or a plain combinational path. The cell holds one register that can act as a D, T or JK flip-flop. Its clock comes from a global high-speed line or from one of the sum terms, and each cell has its own clock polarity.

A global preset and a global reset reach every cell. A global type-override line lets a cell that is set up for it load as a D register and count as a T or JK register. The switch can happen at run time, edge by edge. Three independent outputs carry, as selected, the register state, the raw sum terms, or the output-enable/feedback term.

Top module: `mc_logic_cell`

## Requirements
- R1: With `cfg[1:0]` at 00 or 11 (D type) and no override active, Q takes `sum_a` on each active clock edge.
- R2: With `cfg[1:0]`=01 (T type), Q inverts on an active edge when `sum_a`=1 and keeps its value when `sum_a`=0. `g_rtype` has no effect in this type.
- R3: With `cfg[1:0]`=10 (JK type), J=`sum_a` and K=`sum_b`. On an active edge, 0/0 holds, 1/0 sets, 0/1 clears and 1/1 inverts Q.
- R4: When a D-type cell has `cfg[2]`=1 and `g_rtype`=1 at a clock edge, that edge acts as T (`cfg[3]`=0) or as JK (`cfg[3]`=1). With `cfg[2]`=0, `g_rtype` is ignored.
- R5: `cfg[5:4]` picks the register clock: 00 or 11 the global `clk_hs`, 01 `sum_c`, 10 `sum_d`. Edges of unselected sources do not change Q.
- R6: `cfg[6]`=1 makes the falling edge of the selected clock active, and the rising edge does not update Q.
- R7: `g_preset`, or `sum_b` when `cfg[7]`=1, sets Q to 1 at once, without a clock edge.
- R8: `g_reset`, or `sum_c` when `cfg[8]`=1, or `rst_n` low, clears Q at once. Clearing wins over presetting.
- R9: While `rst_n` is low, Q is 0, and Q is still 0 when `rst_n` is released.
- R10: `y0` (selector `cfg[10:9]`) and `y1` (selector `cfg[12:11]`) each carry Q (00), `sum_a` (01), `sum_b` (10) or `sum_c` (11).
- R11: `y2` carries `sum_d` as the output-enable/feedback term when `cfg[13]`=0, and Q as a buried register output when `cfg[13]`=1.
- R12: With `cfg[7]`=0, `sum_b` does not preset the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hs | input | 1 | Global high-speed clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg | input | 14 | Static configuration word (field map in requirements) |
| sum_a | input | 1 | Sum term A: data, T or J input, or path |
| sum_b | input | 1 | Sum term B: K input, preset, or path |
| sum_c | input | 1 | Sum term C: clock, reset, or path |
| sum_d | input | 1 | Sum term D: clock, output enable, or feedback |
| g_preset | input | 1 | Global asynchronous preset |
| g_reset | input | 1 | Global asynchronous reset |
| g_rtype | input | 1 | Global register-type override |
| y0 | output | 1 | Selectable output 0 |
| y1 | output | 1 | Selectable output 1 |
| y2 | output | 1 | Enable/feedback or buried register output |

## Verification
The next-state properties assume that the register runs from `clk_hs` without inversion, and that the configuration and sum terms change only between clock edges. The stimulus drives every input on the falling edge of `clk_hs`. It changes the clock source only while the old and new clock levels match, so the switch itself never makes an edge. The property that clearing wins also assumes that no configuration routes `sum_c` to both clock and reset. The bench never sets up such a cell.

// File: rtl/mc_logic_cell.sv
module mc_logic_cell (
  input  logic        clk_hs,
  input  logic        rst_n,
  input  logic [13:0] cfg,
  input  logic        sum_a,
  input  logic        sum_b,
  input  logic        sum_c,
  input  logic        sum_d,
  input  logic        g_preset,
  input  logic        g_reset,
  input  logic        g_rtype,
  output logic        y0,
  output logic        y1,
  output logic        y2
);
  localparam logic [1:0] KIND_T  = 2'b01;
  localparam logic [1:0] KIND_JK = 2'b10;

  logic q;
  logic is_d, alt, use_t, use_jk, d_next;
  logic src_clk, reg_clk, clr, set;

  assign is_d   = (cfg[1:0] != KIND_T) && (cfg[1:0] != KIND_JK);
  assign alt    = is_d & cfg[2] & g_rtype;
  assign use_t  = (cfg[1:0] == KIND_T)  | (alt & ~cfg[3]);
  assign use_jk = (cfg[1:0] == KIND_JK) | (alt &  cfg[3]);

  always_comb begin
    if (use_jk)     d_next = (sum_a & ~q) | (~sum_b & q);
    else if (use_t) d_next = q ^ sum_a;
    else            d_next = sum_a;
  end

  always_comb begin
    case (cfg[5:4])
      2'b01:   src_clk = sum_c;
      2'b10:   src_clk = sum_d;
      default: src_clk = clk_hs;
    endcase
  end

  assign reg_clk = src_clk ^ cfg[6];
  assign clr     = ~rst_n | g_reset | (cfg[8] & sum_c);
  assign set     = g_preset | (cfg[7] & sum_b);

  always_ff @(posedge reg_clk or posedge clr or posedge set) begin
    if (clr)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else          q <= d_next;
  end

  function automatic logic pick(input logic [1:0] s, input logic qv,
                                input logic a, input logic b, input logic c);
    case (s)
      2'b00:   pick = qv;
      2'b01:   pick = a;
      2'b10:   pick = b;
      default: pick = c;
    endcase
  endfunction

  assign y0 = pick(cfg[10:9],  q, sum_a, sum_b, sum_c);
  assign y1 = pick(cfg[12:11], q, sum_a, sum_b, sum_c);
  assign y2 = cfg[13] ? q : sum_d;
endmodule

module mc_logic_cell_chk (
  input logic        clk_hs,
  input logic        rst_n,
  input logic [13:0] cfg,
  input logic        sum_a,
  input logic        sum_b,
  input logic        sum_c,
  input logic        g_preset,
  input logic        g_reset,
  input logic        g_rtype,
  input logic        q
);
  logic hs_plain, any_clr, any_set, ov, as_t, as_jk, as_d;
  assign hs_plain = (cfg[5:4] == 2'b00 || cfg[5:4] == 2'b11) && !cfg[6];
  assign any_clr  = g_reset | (cfg[8] & sum_c);
  assign any_set  = g_preset | (cfg[7] & sum_b);
  assign ov       = (cfg[1:0] == 2'b00 || cfg[1:0] == 2'b11) && cfg[2] && g_rtype;
  assign as_t     = (cfg[1:0] == 2'b01) || (ov && !cfg[3]);
  assign as_jk    = (cfg[1:0] == 2'b10) || (ov && cfg[3]);
  assign as_d     = !as_t && !as_jk;

  a_r1_d_load: assert property (@(posedge clk_hs) disable iff (!rst_n)
    (hs_plain && as_d && !any_clr && !any_set) |=> (q == $past(sum_a) || any_clr || any_set));
  a_r2_t_hold: assert property (@(posedge clk_hs) disable iff (!rst_n)
    (hs_plain && as_t && !sum_a && !any_clr && !any_set) |=> (q == $past(q) || any_clr || any_set));
  a_r3_jk_set: assert property (@(posedge clk_hs) disable iff (!rst_n)
    (hs_plain && as_jk && sum_a && !sum_b && !any_clr && !any_set) |=> (q || any_clr || any_set));
  a_r7_preset: assert property (@(posedge clk_hs) disable iff (!rst_n)
    (any_set && !any_clr) |-> q);
  a_r8_clear_wins: assert property (@(posedge clk_hs) disable iff (!rst_n)
    any_clr |-> !q);
  a_r9_start_clear: assert property (@(posedge clk_hs) disable iff (g_reset)
    $rose(rst_n) |-> !q);
endmodule

bind mc_logic_cell mc_logic_cell_chk u_chk (
  .clk_hs(clk_hs), .rst_n(rst_n), .cfg(cfg), .sum_a(sum_a), .sum_b(sum_b),
  .sum_c(sum_c), .g_preset(g_preset), .g_reset(g_reset), .g_rtype(g_rtype), .q(q)
);

// File: tb/tb_mc_logic_cell.sv
`timescale 1ns/100ps
module tb_mc_logic_cell;
  logic clk_hs = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] cfg = '0;
  logic sum_a = 0, sum_b = 0, sum_c = 0, sum_d = 0;
  logic g_preset = 0, g_reset = 0, g_rtype = 0;
  logic y0, y1, y2;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_hs = ~clk_hs;

  mc_logic_cell dut (.clk_hs(clk_hs), .rst_n(rst_n), .cfg(cfg), .sum_a(sum_a),
    .sum_b(sum_b), .sum_c(sum_c), .sum_d(sum_d), .g_preset(g_preset),
    .g_reset(g_reset), .g_rtype(g_rtype), .y0(y0), .y1(y1), .y2(y2));

  // {kind[1:0], ovr_en, alt_jk, a, b, rtype, expected Q}
  localparam int NV = 22;
  localparam logic [7:0] VEC [0:NV-1] = '{
    8'b00001001, 8'b00001011, 8'b00000000, 8'b00001001,
    8'b01001000, 8'b01001001, 8'b01000001,
    8'b10000001, 8'b10000100, 8'b10001001, 8'b10001100, 8'b10001101,
    8'b00100000, 8'b00101011, 8'b00101010, 8'b00100010, 8'b00101001,
    8'b00110110, 8'b00111111, 8'b00110100,
    8'b01101011, 8'b00000000};

  task automatic chk(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_hs);
    #1 chk("R9 q in reset", y0, 1'b0);
    @(negedge clk_hs) rst_n = 1'b1;
    @(posedge clk_hs); #1 chk("R9 q after release", y0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_hs);
      cfg = {10'b0, VEC[i][4], VEC[i][5], VEC[i][7:6]};
      sum_a = VEC[i][3]; sum_b = VEC[i][2]; g_rtype = VEC[i][1];
      @(posedge clk_hs); #1;
      chk($sformatf("R1/R2/R3/R4 vector %0d", i), y0, VEC[i][0]);
    end

    // R10 R11 routing, Q=0 here
    @(negedge clk_hs);
    g_rtype = 0; sum_b = 0;
    cfg = 14'((1 << 9) | (2 << 11)); sum_a = 1; sum_c = 1; sum_d = 0;
    #1 chk("R10 y0=A", y0, 1'b1); chk("R10 y1=B", y1, 1'b0); chk("R11 y2=D", y2, 1'b0);
    @(negedge clk_hs);
    cfg = 14'((3 << 9) | (1 << 11)); sum_d = 1; sum_c = 0;
    #1 chk("R10 y0=C", y0, 1'b0); chk("R10 y1=A", y1, 1'b1); chk("R11 y2=D hi", y2, 1'b1);
    @(negedge clk_hs);
    cfg = 14'(1 << 13); sum_d = 0; sum_a = 0;
    #1 chk("R10 y0=Q", y0, 1'b1); chk("R10 y1=Q", y1, 1'b1); chk("R11 y2=Q", y2, 1'b1);
    @(negedge clk_hs); #1 chk("R1 load 0", y0, 1'b0);

    // R7 R8 global async
    @(negedge clk_hs); cfg = '0; g_preset = 1;
    #1 chk("R7 global preset", y0, 1'b1);
    @(negedge clk_hs); #0.5 chk("R7 preset held", y0, 1'b1);
    g_reset = 1;
    #0.5 chk("R8 reset wins", y0, 1'b0);
    @(negedge clk_hs); g_reset = 0; g_preset = 0;
    @(negedge clk_hs); #1 chk("R8 after release", y0, 1'b0);

    // R7 sum-B preset, R12 no effect when not routed
    @(negedge clk_hs); cfg = 14'(1 << 7); sum_b = 1;
    #1 chk("R7 sum_b preset", y0, 1'b1);
    @(negedge clk_hs); sum_b = 0;
    @(negedge clk_hs); cfg = '0; sum_b = 1;
    #1 chk("R12 sum_b ignored", y0, 1'b0);
    @(posedge clk_hs); #1 chk("R12 sum_b ignored edge", y0, 1'b0);
    @(negedge clk_hs); sum_b = 0;

    // R8 sum-C reset
    cfg = 14'(1 << 8); sum_a = 1;
    @(posedge clk_hs); #1 chk("R1 load 1", y0, 1'b1);
    @(negedge clk_hs); sum_c = 1;
    #1 chk("R8 sum_c reset", y0, 1'b0);
    @(posedge clk_hs); #1 chk("R8 sum_c reset held", y0, 1'b0);
    @(negedge clk_hs); sum_c = 0; sum_a = 0;
    @(posedge clk_hs); #1;

    // R5 clock from sum_c, hs ignored
    @(negedge clk_hs); cfg = 14'(1 << 4); sum_a = 1;
    repeat (2) @(posedge clk_hs);
    #1 chk("R5 hs ignored", y0, 1'b0);
    @(negedge clk_hs); sum_c = 1;
    #1 chk("R5 sum_c clock", y0, 1'b1);
    sum_c = 0; sum_d = 1;
    // R6 inverted sum_d clock
    #0.5 cfg = 14'((2 << 4) | (1 << 6)); sum_a = 0;
    #0.2 chk("R5 switch no edge", y0, 1'b1);
    sum_d = 0;
    #0.2 chk("R6 falling edge captures", y0, 1'b0);
    sum_a = 1; #0.1 sum_d = 1;
    #0.2 chk("R6 rising edge ignored", y0, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule